// File: doc/BRIEF.md
# Periodic Sampler With Read Handshake

This block is the application-side end of a read-only serial sensor link. It waits a fixed number of clock cycles, requests one reading from a serial read interface, and keeps the returned 16-bit word in a display register until the next reading. The serializer that shifts bits in from the sensor lies outside this block. From here it is only a responder that answers a request with a response-valid flag and a data word.

The exchange is a four-phase handshake. `req_o` rising opens a read. The responder raises `rsp_valid` with the word on `rsp_data`, and the word stays valid for as long as the flag is high. The sampler captures the word on the first clock edge at which it sees both signals high. It then drops `req_o`, and that falling edge is the acknowledgement.

Back-pressure sits entirely with the responder. It may keep `rsp_valid` high for as many cycles as it needs. The sampler issues no new request until it has seen `rsp_valid` low, and only then does it start the next interval. If no response arrives within a bounded wait, the sampler abandons the request and starts a new interval. When the responder packs its sample bits into the middle of the word with zeros around them, they appear in the same middle positions of the display.

Top module: `periodic_sampler`

## Requirements
- R1: While `rst_n` is low, and on the first clock edge after it rises, `req_o` is 0 and `disp_o` is 0. The interval count restarts from zero.
- R2: `req_o` rises on exactly the PERIOD-th clock edge after the sampler enters idle. Idle is entered at reset release, at the edge where `rsp_valid` is seen low after an acknowledgement, or at the edge of a timeout. PERIOD defaults to 40000 and may be set as low as 2.
- R3: Once high, `req_o` stays high until a clock edge at which `rsp_valid` is 1. On that edge `req_o` falls.
- R4: `disp_o` takes the value of `rsp_data` on the clock edge where `req_o` and `rsp_valid` are both 1. At every other edge it keeps its value.
- R5: After an acknowledgement, `req_o` stays 0 for as long as `rsp_valid` stays 1. The interval in R2 begins only at the edge that sees `rsp_valid` at 0.
- R6: If `rsp_valid` is 0 on each of the TIMEOUT edges that follow the rise of `req_o`, then `req_o` falls on the TIMEOUT-th edge and `disp_o` keeps its old value.
- R7: When `rsp_valid` first reads 1 on the same edge at which the wait in R6 runs out, the word is captured as in R4 and the timeout does not apply.
- R8: While `req_o` is 0, changes on `rsp_valid` and `rsp_data` have no effect on `disp_o` and do not alter the R2 interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rsp_valid | input | 1 | Responder flag: the word on rsp_data is valid |
| rsp_data | input | 16 | Word returned by the serial read interface |
| req_o | output | 1 | Read request; its fall acknowledges the word |
| disp_o | output | 16 | Display register holding the last captured word |

## Verification
Two events can land on the same clock edge: the capture of a response and the expiry of the response wait. The bench provokes the clash by raising `rsp_valid` exactly TIMEOUT-1 cycles after it sees `req_o` high. It counts as correct only if `req_o` falls on that edge and `disp_o` shows the new word, not the old one. Neighbouring delays of TIMEOUT and beyond are run as well, and these must leave the display unchanged.

// File: rtl/sampler_pkg.sv
package sampler_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_REQ  = 2'd1,
    PH_ACK  = 2'd2
  } phase_t;
endpackage

// File: rtl/span_counter.sv
module span_counter #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic hit
);
  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign hit = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || hit) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/word_hold.sv
module word_hold #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
    end else if (load) begin
      dout <= din;
    end
  end
endmodule

// File: rtl/periodic_sampler.sv
module periodic_sampler #(
  parameter int W       = 16,
  parameter int PERIOD  = 40000,
  parameter int TIMEOUT = 1024
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rsp_valid,
  input  logic [W-1:0] rsp_data,
  output logic         req_o,
  output logic [W-1:0] disp_o
);
  import sampler_pkg::*;

  phase_t phase, phase_nx;
  logic   tick_due;
  logic   wait_over;
  logic   take;

  span_counter #(.LIMIT(PERIOD)) u_interval (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (phase == PH_IDLE),
    .hit  (tick_due)
  );

  span_counter #(.LIMIT(TIMEOUT)) u_wait (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (phase == PH_REQ),
    .hit  (wait_over)
  );

  assign take  = (phase == PH_REQ) && rsp_valid;
  assign req_o = (phase == PH_REQ);

  word_hold #(.W(W)) u_disp (
    .clk  (clk),
    .rst_n(rst_n),
    .load (take),
    .din  (rsp_data),
    .dout (disp_o)
  );

  always_comb begin
    phase_nx = phase;
    case (phase)
      PH_IDLE: if (tick_due) phase_nx = PH_REQ;
      PH_REQ: begin
        if (rsp_valid)      phase_nx = PH_ACK;
        else if (wait_over) phase_nx = PH_IDLE;
      end
      PH_ACK:  if (!rsp_valid) phase_nx = PH_IDLE;
      default: phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_nx;
  end
endmodule

// File: rtl/sampler_chk.sv
module sampler_chk #(
  parameter int W    = 16,
  parameter int TOUT = 1024
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rsp_valid,
  input logic [W-1:0] rsp_data,
  input logic         req_o,
  input logic [W-1:0] disp_o
);
  localparam int CW = $clog2(TOUT + 2);
  logic [CW-1:0] starve;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  starve <= '0;
    else if (req_o && !rsp_valid) starve <= starve + 1'b1;
    else                         starve <= '0;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!req_o && disp_o == '0));

  // R3
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && rsp_valid) |=> !req_o);

  // R4
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && rsp_valid) |=> disp_o == $past(rsp_data));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_o && rsp_valid) |=> $stable(disp_o));

  // R6
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (starve < CW'(TOUT)));
endmodule

bind periodic_sampler sampler_chk #(.W(W), .TOUT(TIMEOUT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rsp_valid(rsp_valid),
  .rsp_data (rsp_data),
  .req_o    (req_o),
  .disp_o   (disp_o)
);

// File: tb/tb_periodic_sampler.sv
module tb_periodic_sampler;
  localparam int W   = 16;
  localparam int PER = 6;
  localparam int TO  = 5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rsp_valid = 1'b0;
  logic [W-1:0] rsp_data = '0;
  logic         req_o;
  logic [W-1:0] disp_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [W-1:0] shown = '0;

  always #4 clk = ~clk;

  periodic_sampler #(.W(W), .PERIOD(PER), .TIMEOUT(TO)) dut (
    .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .req_o(req_o), .disp_o(disp_o)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int fall_slot(int d);
    return (d < TO) ? d : TO - 1;
  endfunction

  function automatic logic [W-1:0] next_disp(int d, logic [W-1:0] word, logic [W-1:0] prev);
    return (d < TO) ? word : prev;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called just after the idle entry edge has been observed.
  task automatic idle_phase();
    int n = 0;
    bit bad = 0;
    while (1) begin
      rsp_valid = 1'($urandom_range(0, 1));
      rsp_data  = W'($urandom);
      @(negedge clk);
      n++;
      if (disp_o !== shown) bad = 1;
      if (req_o || n > PER + 4) break;
    end
    chk(n == PER, "R2 interval", n, PER);
    chk(!bad, "R8 idle inputs ignored", int'(disp_o), int'(shown));
  endtask

  task automatic one_read(int d, int hold, logic [W-1:0] word);
    int fell = -1;
    bit lowbad = 0;
    for (int i = 0; i <= TO + 4; i++) begin
      rsp_valid = (i >= d);
      rsp_data  = (i >= d) ? word : W'($urandom);
      @(negedge clk);
      if (!req_o) begin fell = i; break; end
    end
    chk(fell == fall_slot(d), (d == TO - 1) ? "R7 clash edge" : (d < TO ? "R3 drop" : "R6 timeout"),
        fell, fall_slot(d));
    shown = next_disp(d, word, shown);
    chk(disp_o === shown, (d == TO - 1) ? "R7 capture wins" : (d < TO ? "R4 capture" : "R6 keep"),
        int'(disp_o), int'(shown));
    if (d < TO) begin
      for (int h = 0; h < hold; h++) begin
        rsp_data = W'($urandom);
        @(negedge clk);
        if (req_o || disp_o !== shown) lowbad = 1;
      end
      chk(!lowbad, "R5 wait for valid low", int'(req_o), 0);
      rsp_valid = 1'b0;
      @(negedge clk);
    end
    idle_phase();
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(req_o == 1'b0 && disp_o == '0, "R1 reset", int'(disp_o), 0);
    rst_n = 1'b1;
    idle_phase();
    one_read(0, 0, 16'h1FE0);
    one_read(TO - 1, 2, 16'h0A50);
    one_read(TO, 0, 16'hFFFF);
    one_read(TO + 3, 0, 16'h1234);
    one_read(1, 4, 16'h0000);
    for (int k = 0; k < 30; k++)
      one_read(int'($urandom_range(0, TO + 2)), int'($urandom_range(0, 4)), W'($urandom));
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule